// File: doc/BRIEF.md
# Programmable Clock Divider with Selectable Divisor Encoding

This block divides a single input clock by a divisor that is programmed through a write port. A divisor code is taken from a bit field of the written word; the position of the field is a parameter. A compile-time encoding parameter chooses how the code becomes a divisor. The code can be taken plus one, taken as it is, taken as a power of two, or used as an index into a small table of divisors, where a zero entry marks a forbidden code. Codes that fall outside the legal divisor range, or that hit a zero table entry, are rejected.

The block produces a divided clock with close to 50% duty and a one-input-cycle enable strobe at the end of each output period. It never gates its output. A new divisor is held pending and takes effect only at the next period boundary, so no output period is cut short. A sticky flag reports a rejected write. An autoidle enable bit is also carried in the written word, and a parameter sets its polarity.

Top module: `clkdiv_prog`

## Requirements
- R1: In plus-one encoding the applied divisor is the code plus one (code 0 divides by 1, code 7 by 8).
- R2: In direct encoding the applied divisor equals the code. Code 0 is illegal, and so is any code above the maximum divisor.
- R3: In power-of-two encoding the applied divisor is 2 raised to the code (0, 1, 2, 3 give 1, 2, 4, 8).
- R4: In table encoding the code selects an 8-bit entry of the divisor table, entry k at bits [8k+7:8k]. The default table is 4, 8, 0, 16, and a zero entry makes its code illegal.
- R5: The code is read from wr_data starting at bit FIELD_SHIFT. Its width is the smallest that holds the largest legal code. Other bits of wr_data, apart from the autoidle bit, have no effect on the divisor.
- R6: Outside table encoding, a decoded divisor below MIN_DIV or above MAX_DIV is illegal and is never applied.
- R7: A write with an illegal code leaves the divisor unchanged and sets code_err. code_err stays set through further illegal writes and clears on the next legal write.
- R8: A legal write becomes pending. It is applied at the first period boundary after the write cycle, and the output period in progress always runs to its full length.
- R9: For divisor N, each output period lasts N input cycles. div_tick is high only in the last cycle of the period. div_clk is high for the first (N+1)/2 cycles (integer division), so for N=1 div_tick is high every cycle.
- R10: autoidle_on follows bit IDLE_BIT of the last write, inverted when IDLE_INV is 1.
- R11: After reset, code_err is 0, the autoidle bit is 0, and the divider runs at the divisor of reset code 0. In direct encoding the reset code is 1. With the default parameters this gives a divisor of 1, or 4 in table encoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | REG_W | Control word: divisor code field and autoidle bit |
| div_clk | output | 1 | Divided clock |
| div_tick | output | 1 | One-cycle enable at the last input cycle of each output period |
| code_err | output | 1 | Sticky flag for a rejected divisor code |
| autoidle_on | output | 1 | Effective autoidle enable after polarity |

## Verification
code_err and autoidle_on are registered on the write edge, so the bench reads them at the falling edge right after that edge. A new divisor shows up only after the first div_tick that follows the write. The bench therefore waits for that strobe, then counts input cycles and high cycles of div_clk up to the next strobe, and compares these counts with the period and duty computed from the code. For a write that lands mid-period, the bench counts the cycles left until the strobe and expects the remainder of the old full period.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic [1:0] {
        ENC_PLUS1  = 2'd0,
        ENC_DIRECT = 2'd1,
        ENC_POW2   = 2'd2,
        ENC_TABLE  = 2'd3
    } enc_mode_e;

    typedef struct packed {
        logic pend;
        logic err;
        logic idle;
    } ctl_flags_t;

    function automatic int bits_for(int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

    function automatic int field_bits(enc_mode_e m, int unsigned maxd, int unsigned tbln);
        case (m)
            ENC_PLUS1:  return bits_for(maxd - 1);
            ENC_DIRECT: return bits_for(maxd);
            ENC_POW2:   return bits_for($clog2(maxd));
            default:    return bits_for(tbln - 1);
        endcase
    endfunction

endpackage

// File: rtl/clkdiv_decode.sv
module clkdiv_decode
    import clkdiv_pkg::*;
#(
    parameter enc_mode_e   MODE    = ENC_PLUS1,
    parameter int          FW      = 3,
    parameter int          DIV_W   = 4,
    parameter int unsigned MIN_DIV = 1,
    parameter int unsigned MAX_DIV = 8,
    parameter int          TBL_N   = 4,
    parameter int          TBL_EW  = 8,
    parameter logic [TBL_N*TBL_EW-1:0] DIV_TBL = '0
) (
    input  logic [FW-1:0]    code,
    output logic [DIV_W-1:0] div,
    output logic             ok
);
    int unsigned d;

    if (MODE == ENC_TABLE) begin : g_tbl
        always_comb begin
            d = 0;
            for (int i = 0; i < TBL_N; i++) begin
                if (32'(code) == i)
                    d = 32'(DIV_TBL[i*TBL_EW +: TBL_EW]);
            end
            ok = (d != 0);
        end
    end else begin : g_arith
        always_comb begin
            case (MODE)
                ENC_PLUS1:  d = 32'(code) + 1;
                ENC_DIRECT: d = 32'(code);
                ENC_POW2:   d = (32'(code) < 31) ? (32'd1 << code) : 32'd0;
                default:    d = 0;
            endcase
            ok = (d >= MIN_DIV) && (d <= MAX_DIV) && (d != 0);
        end
    end

    assign div = DIV_W'(d);

endmodule

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
    import clkdiv_pkg::*;
#(
    parameter int REG_W    = 32,
    parameter int FW       = 3,
    parameter int SHIFT    = 0,
    parameter int IDLE_BIT = 31,
    parameter int DIV_W    = 4,
    parameter logic [DIV_W-1:0] RST_DIV = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [DIV_W-1:0] dec_div,
    input  logic             dec_ok,
    input  logic             boundary,
    output logic [FW-1:0]    code,
    output logic [DIV_W-1:0] cur_div,
    output logic             err,
    output logic             idle_bit
);
    ctl_flags_t       st;
    logic [DIV_W-1:0] pend_div;
    logic             unused_bits;

    assign code        = wr_data[SHIFT +: FW];
    assign unused_bits = ^wr_data;
    assign err         = st.err;
    assign idle_bit    = st.idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_div  <= RST_DIV;
            pend_div <= '0;
            st       <= '0;
        end else begin
            if (boundary && st.pend) begin
                cur_div <= pend_div;
                st.pend <= 1'b0;
            end
            if (wr_en) begin
                st.err  <= !dec_ok;
                st.idle <= wr_data[IDLE_BIT];
                if (dec_ok) begin
                    pend_div <= dec_div;
                    st.pend  <= 1'b1;
                end
            end
        end
    end

    // R7: rejected code raises the flag on the next cycle
    assert_bad_code_flags_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !dec_ok) |=> err);
    // R7: flag is sticky while no write happens
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (err && !wr_en) |=> err);
    // R8: divisor only moves at a period boundary
    assert_apply_at_edge_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_div) |-> $past(boundary));

endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick,
    output logic             clk_out
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W:0]   half;

    assign tick    = (cnt == div - 1'b1);
    assign half    = ({1'b0, div} + (DIV_W+1)'(1)) >> 1;
    assign clk_out = ({1'b0, cnt} < half);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // R9: phase counter never leaves the current period
    assert_cnt_in_period_R9: assert property (@(posedge clk) disable iff (rst)
        cnt < div);

endmodule

// File: rtl/clkdiv_prog.sv
module clkdiv_prog
    import clkdiv_pkg::*;
#(
    parameter int          REG_W       = 32,
    parameter enc_mode_e   MODE        = ENC_PLUS1,
    parameter int          FIELD_SHIFT = 0,
    parameter int unsigned MIN_DIV     = 1,
    parameter int unsigned MAX_DIV     = 8,
    parameter int          TBL_N       = 4,
    parameter int          TBL_EW      = 8,
    parameter logic [TBL_N*TBL_EW-1:0] DIV_TBL = 32'h1000_0804,
    parameter int          IDLE_BIT    = 31,
    parameter logic        IDLE_INV    = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic             div_clk,
    output logic             div_tick,
    output logic             code_err,
    output logic             autoidle_on
);
    localparam int FW    = field_bits(MODE, MAX_DIV, TBL_N);
    localparam int DIV_W = (MODE == ENC_TABLE) ? TBL_EW : bits_for(MAX_DIV);
    localparam logic [DIV_W-1:0] RST_DIV =
        (MODE == ENC_TABLE) ? DIV_W'(DIV_TBL[TBL_EW-1:0]) : DIV_W'(1);

    logic [FW-1:0]    code;
    logic [DIV_W-1:0] dec_div, cur_div;
    logic             dec_ok, idle_bit;

    clkdiv_decode #(
        .MODE(MODE), .FW(FW), .DIV_W(DIV_W), .MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV),
        .TBL_N(TBL_N), .TBL_EW(TBL_EW), .DIV_TBL(DIV_TBL)
    ) u_dec (
        .code(code), .div(dec_div), .ok(dec_ok)
    );

    clkdiv_ctrl #(
        .REG_W(REG_W), .FW(FW), .SHIFT(FIELD_SHIFT), .IDLE_BIT(IDLE_BIT),
        .DIV_W(DIV_W), .RST_DIV(RST_DIV)
    ) u_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .dec_div(dec_div), .dec_ok(dec_ok), .boundary(div_tick),
        .code(code), .cur_div(cur_div), .err(code_err), .idle_bit(idle_bit)
    );

    clkdiv_core #(.DIV_W(DIV_W)) u_core (
        .clk(clk), .rst(rst), .div(cur_div), .tick(div_tick), .clk_out(div_clk)
    );

    assign autoidle_on = idle_bit ^ IDLE_INV;

    // R7: a legal write clears the error flag
    assert_err_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dec_ok) |=> !code_err);
    // R6: applied divisor stays inside the legal range
    assert_applied_legal_R6: assert property (@(posedge clk) disable iff (rst)
        (MODE == ENC_TABLE) ||
        ((32'(cur_div) >= MIN_DIV) && (32'(cur_div) <= MAX_DIV)));

endmodule

// File: tb/sim_clkdiv_prog.sv
module sim_clkdiv_prog;
    import clkdiv_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  wr_en = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  dclk, dtick, derr, didle;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    clkdiv_prog #(.MODE(ENC_PLUS1), .FIELD_SHIFT(0)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en[0]), .wr_data(wr_data),
        .div_clk(dclk[0]), .div_tick(dtick[0]), .code_err(derr[0]), .autoidle_on(didle[0]));
    clkdiv_prog #(.MODE(ENC_DIRECT), .FIELD_SHIFT(8), .IDLE_INV(1'b1)) u1 (
        .clk(clk), .rst(rst), .wr_en(wr_en[1]), .wr_data(wr_data),
        .div_clk(dclk[1]), .div_tick(dtick[1]), .code_err(derr[1]), .autoidle_on(didle[1]));
    clkdiv_prog #(.MODE(ENC_POW2), .FIELD_SHIFT(4)) u2 (
        .clk(clk), .rst(rst), .wr_en(wr_en[2]), .wr_data(wr_data),
        .div_clk(dclk[2]), .div_tick(dtick[2]), .code_err(derr[2]), .autoidle_on(didle[2]));
    clkdiv_prog #(.MODE(ENC_TABLE), .FIELD_SHIFT(24)) u3 (
        .clk(clk), .rst(rst), .wr_en(wr_en[3]), .wr_data(wr_data),
        .div_clk(dclk[3]), .div_tick(dtick[3]), .code_err(derr[3]), .autoidle_on(didle[3]));

    function automatic int fw_of(int idx);
        case (idx) 0: return 3; 1: return 4; default: return 2; endcase
    endfunction

    function automatic int sh_of(int idx);
        case (idx) 0: return 0; 1: return 8; 2: return 4; default: return 24; endcase
    endfunction

    // expected divisor, 0 means illegal code
    function automatic int exp_div(int idx, int c);
        case (idx)
            0: return c + 1;
            1: return (c >= 1 && c <= 8) ? c : 0;
            2: return 1 << c;
            default: case (c) 0: return 4; 1: return 8; 2: return 0; default: return 16; endcase
        endcase
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(int idx, int code, logic [31:0] extra);
        @(negedge clk);
        wr_data = (32'(code) << sh_of(idx)) | extra;
        wr_en[idx] = 1'b1;
        @(negedge clk);
        wr_en = '0;
    endtask

    task automatic meas(int idx, output int p, output int h);
        while (!dtick[idx]) @(negedge clk);
        p = 0;
        h = 0;
        do begin
            @(negedge clk);
            p++;
            if (dclk[idx]) h++;
        end while (!dtick[idx]);
    endtask

    initial begin
        int p, h, n;
        int prev [4];
        string tag [4];
        tag[0] = "R1"; tag[1] = "R2"; tag[2] = "R3"; tag[3] = "R4";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        chk(derr == 4'b0000, "R11 err", int'(derr), 0);
        chk(didle == 4'b0010, "R11 R10 idle", int'(didle), 2);
        for (int i = 0; i < 4; i++) begin
            prev[i] = (i == 3) ? 4 : 1;
            meas(i, p, h);
            chk(p == prev[i], "R11 period", p, prev[i]);
            chk(h == (prev[i] + 1) / 2, "R11 R9 high", h, (prev[i] + 1) / 2);
        end
        // R1..R6, R9: sweep every code of every encoding, with noise in other bits (R5)
        for (int i = 0; i < 4; i++) begin
            for (int c = 0; c < (1 << fw_of(i)); c++) begin
                int e, want;
                logic [31:0] noise;
                noise = 32'h5A5A_5A5A & ~(((32'd1 << fw_of(i)) - 1) << sh_of(i)) & 32'h7FFF_FFFF;
                e = exp_div(i, c);
                wr(i, c, noise);
                chk(derr[i] == (e == 0), {tag[i], " R6 R7 err"}, int'(derr[i]), int'(e == 0));
                want = (e != 0) ? e : prev[i];
                meas(i, p, h);
                chk(p == want, {tag[i], " R5 period"}, p, want);
                chk(h == (want + 1) / 2, "R9 high", h, (want + 1) / 2);
                prev[i] = want;
            end
        end
        // R7: sticky error, divisor held, cleared by a legal write
        wr(1, 3, 32'h0);
        chk(derr[1] == 1'b0, "R7 clear", int'(derr[1]), 0);
        wr(1, 0, 32'h0);
        chk(derr[1] == 1'b1, "R7 set", int'(derr[1]), 1);
        wr(1, 12, 32'h0);
        chk(derr[1] == 1'b1, "R7 sticky", int'(derr[1]), 1);
        meas(1, p, h);
        chk(p == 3, "R7 hold", p, 3);
        wr(1, 5, 32'h0);
        chk(derr[1] == 1'b0, "R7 clear again", int'(derr[1]), 0);
        meas(1, p, h);
        chk(p == 5, "R7 apply", p, 5);
        // R10: autoidle polarity
        wr(0, 1, 32'h8000_0000);
        chk(didle[0] == 1'b1, "R10 plain", int'(didle[0]), 1);
        wr(1, 2, 32'h8000_0000);
        chk(didle[1] == 1'b0, "R10 inverted", int'(didle[1]), 0);
        wr(0, 1, 32'h0);
        chk(didle[0] == 1'b0, "R10 off", int'(didle[0]), 0);
        // R8: write mid-period does not shorten the running period
        wr(0, 7, 32'h0);
        meas(0, p, h);
        chk(p == 8, "R8 setup", p, 8);
        @(negedge clk);
        @(negedge clk);
        wr_data = 32'd1;
        wr_en[0] = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            wr_en = '0;
            n++;
        end while (!dtick[0]);
        chk(n == 6, "R8 remainder", n, 6);
        meas(0, p, h);
        chk(p == 2, "R8 new period", p, 2);
        chk(h == 1, "R9 high div2", h, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule